// File: doc/BRIEF.md
# Flash Write-Buffer Programming Controller

This block models the write path of on-chip program memory as a processor core sees it. Short table writes place bytes, one at a time, into a 64-byte staging buffer. The slot is taken from the low six bits of an address pointer, and the pointer steps forward by one after each write. Nothing reaches the memory array until a long write is launched. A long write launches only through a guarded path: two key bytes go to a separate key port in a fixed order, and the very next register access must be a control write that sets both the launch bit and the enable bit.

While a long write runs, the block holds a stall output high for a fixed number of cycles set by a parameter. Every register access is ignored during that time. When the count runs out, the array is updated in one step: a full 64-byte block, a single aligned byte pair, or a 1024-byte erase region filled with ones. In the same cycle the launch bit drops and a done pulse is raised. Programming can only turn bits from 1 to 0, because the array byte is ANDed with the buffer byte. The buffer is never cleared, so its contents carry over into later writes. Read-back goes through a combinational read port.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, ptrOut is 0, ctrlOut is 0, stall and doneIrq are low, and every array byte reads 0xFF.
- R2: A table write stores tblData into buffer slot ptrOut[5:0] and then adds one to ptrOut; the array is not changed.
- R3: Key 0x55 followed by key 0xAA, then a control write with bit 0 (launch) and bit 2 (enable) both set, raises stall and sets ctrlOut bit 0 in the next cycle; stall then stays high for exactly WRITE_CYCLES cycles.
- R4: A wrong key byte, keys in the wrong order, or any other register access between the key sequence and the control write prevents the launch: stall stays low, ctrlOut bit 0 stays 0 and the array is unchanged.
- R5: A control write with the launch bit set but the enable bit (bit 2) clear does not launch, even after a correct key sequence.
- R6: A block write (bits 1 and 4 clear) ANDs all 64 buffer bytes into the 64-byte array block selected by pointer bits [10:6] at launch; bytes outside that block are not changed.
- R7: With word mode (control bit 1) set, only the aligned byte pair at pointer bits [10:1] is programmed, from buffer slots {ptr[5:1],0} and {ptr[5:1],1}.
- R8: The buffer keeps its contents after a write, and a later launch without refilling programs the same data.
- R9: With erase mode (control bit 4) set, the 1024-byte region selected by pointer bit [10] is filled with 0xFF, and the other region is kept.
- R10: When a write ends, stall falls, ctrlOut bit 0 clears and doneIrq is high for exactly that one cycle; the enable and mode bits are kept.
- R11: Table writes, pointer loads and control or key writes made while stall is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ptrLoad | input | 1 | Load the pointer from ptrIn |
| ptrIn | input | 11 | New pointer value |
| tblWr | input | 1 | Table write strobe |
| tblData | input | 8 | Byte for the buffer |
| ctrlWr | input | 1 | Control register write strobe |
| ctrlIn | input | 8 | Control value: bit0 launch, bit1 word mode, bit2 enable, bit4 erase |
| keyWr | input | 1 | Key register write strobe |
| keyIn | input | 8 | Key byte |
| rdAddr | input | 11 | Array read address |
| rdData | output | 8 | Array byte at rdAddr (combinational) |
| ptrOut | output | 11 | Current pointer |
| ctrlOut | output | 8 | Control register contents |
| stall | output | 1 | High while a long write runs |
| doneIrq | output | 1 | One-cycle pulse when a write ends |

## Verification
The hardest state to reach is an access that arrives during a long write. The stimulus has to wait until stall is already high, and only then drive a pointer load together with a table write. The test then confirms that the pointer did not move, and that the buffer byte did not change by programming the same buffer into a second block later. A second hard case is the cancelled key sequence. It needs a correct 0x55/0xAA pair broken by an unrelated pointer load, which shows that the unlocked state really expires. The AND behaviour is exposed by programming one location twice without an erase between the two writes.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
  localparam int BIT_LAUNCH = 0;
  localparam int BIT_WORD   = 1;
  localparam int BIT_ENABLE = 2;
  localparam int BIT_ERASE  = 4;
  localparam logic [7:0] CTRL_KEEP_MASK = 8'h16;

  typedef enum logic [1:0] {
    KEY_IDLE  = 2'd0,
    KEY_HALF  = 2'd1,
    KEY_ARMED = 2'd2
  } keyState_t;

  typedef struct packed {
    logic bufWr;
    logic ptrSet;
    logic latchTgt;
    logic commitBlock;
    logic commitWord;
    logic commitErase;
  } dpStrobe_t;
endpackage

// File: rtl/flash_prog_fsm.sv
module flash_prog_fsm
  import flash_prog_pkg::*;
#(
  parameter int WRITE_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tblWr,
  input  logic       ptrLoad,
  input  logic       ctrlWr,
  input  logic [7:0] ctrlIn,
  input  logic       keyWr,
  input  logic [7:0] keyIn,
  output dpStrobe_t  stb,
  output logic [7:0] ctrlReg,
  output logic       busy,
  output logic       doneIrq
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WRITE_CYCLES - 1);

  keyState_t keySt;
  logic [CNT_W-1:0] cnt;
  logic accept, anyWr, startOk, finish;

  assign accept  = !busy;
  assign anyWr   = tblWr | ptrLoad | ctrlWr | keyWr;
  assign startOk = accept && ctrlWr && ctrlIn[BIT_LAUNCH] && ctrlIn[BIT_ENABLE]
                   && (keySt == KEY_ARMED);
  assign finish  = busy && (cnt == LAST);

  always_comb begin
    stb             = '0;
    stb.bufWr       = accept && tblWr;
    stb.ptrSet      = accept && ptrLoad;
    stb.latchTgt    = startOk;
    stb.commitErase = finish && ctrlReg[BIT_ERASE];
    stb.commitWord  = finish && !ctrlReg[BIT_ERASE] && ctrlReg[BIT_WORD];
    stb.commitBlock = finish && !ctrlReg[BIT_ERASE] && !ctrlReg[BIT_WORD];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keySt   <= KEY_IDLE;
      ctrlReg <= '0;
      busy    <= 1'b0;
      cnt     <= '0;
      doneIrq <= 1'b0;
    end else begin
      doneIrq <= finish;
      if (accept && keyWr) begin
        if (keyIn == KEY_FIRST)
          keySt <= KEY_HALF;
        else if (keySt == KEY_HALF && keyIn == KEY_SECOND)
          keySt <= KEY_ARMED;
        else
          keySt <= KEY_IDLE;
      end else if (accept && anyWr) begin
        keySt <= KEY_IDLE;
      end
      if (accept && ctrlWr)
        ctrlReg <= (ctrlIn & CTRL_KEEP_MASK) | {7'd0, startOk};
      else if (finish)
        ctrlReg[BIT_LAUNCH] <= 1'b0;
      if (startOk) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (finish) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_prog_dp.sv
module flash_prog_dp
  import flash_prog_pkg::*;
#(
  parameter int MEM_BYTES   = 2048,
  parameter int BLOCK_BYTES = 64,
  parameter int ERASE_BYTES = 1024
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpStrobe_t                    stb,
  input  logic [$clog2(MEM_BYTES)-1:0] ptrIn,
  input  logic [7:0]                   tblData,
  input  logic [$clog2(MEM_BYTES)-1:0] rdAddr,
  output logic [7:0]                   rdData,
  output logic [$clog2(MEM_BYTES)-1:0] ptrOut
);
  localparam int AW    = $clog2(MEM_BYTES);
  localparam int BLK_W = $clog2(BLOCK_BYTES);
  localparam int ERS_W = $clog2(ERASE_BYTES);
  localparam logic [AW-1:0] BLK_MASK = ~AW'(BLOCK_BYTES - 1);
  localparam logic [AW-1:0] ERS_MASK = ~AW'(ERASE_BYTES - 1);
  localparam logic [AW-1:0] PAIR_MASK = ~AW'(1);

  logic [7:0]    holdBuf [BLOCK_BYTES];
  logic [7:0]    mem     [MEM_BYTES];
  logic [AW-1:0] ptr, tgt;
  logic [AW-1:0] blkBase, ersBase, pairBase;
  logic [BLK_W-1:0] pairSlot;

  assign ptrOut   = ptr;
  assign rdData   = mem[rdAddr];
  assign blkBase  = tgt & BLK_MASK;
  assign ersBase  = tgt & ERS_MASK;
  assign pairBase = tgt & PAIR_MASK;
  assign pairSlot = pairBase[BLK_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
      tgt <= '0;
      for (int i = 0; i < BLOCK_BYTES; i++) holdBuf[i] <= 8'hFF;
    end else begin
      if (stb.ptrSet)
        ptr <= ptrIn;
      else if (stb.bufWr)
        ptr <= ptr + 1'b1;
      if (stb.bufWr)
        holdBuf[ptr[BLK_W-1:0]] <= tblData;
      if (stb.latchTgt)
        tgt <= ptr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (stb.commitErase) begin
      for (int i = 0; i < ERASE_BYTES; i++)
        mem[ersBase | AW'(i)] <= 8'hFF;
    end else if (stb.commitBlock) begin
      for (int i = 0; i < BLOCK_BYTES; i++)
        mem[blkBase | AW'(i)] <= mem[blkBase | AW'(i)] & holdBuf[i];
    end else if (stb.commitWord) begin
      for (int j = 0; j < 2; j++)
        mem[pairBase | AW'(j)] <= mem[pairBase | AW'(j)] & holdBuf[pairSlot | BLK_W'(j)];
    end
  end

  logic unusedErsW;
  assign unusedErsW = ^ERS_W;
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int MEM_BYTES    = 2048,
  parameter int BLOCK_BYTES  = 64,
  parameter int ERASE_BYTES  = 1024,
  parameter int WRITE_CYCLES = 40
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         ptrLoad,
  input  logic [$clog2(MEM_BYTES)-1:0] ptrIn,
  input  logic                         tblWr,
  input  logic [7:0]                   tblData,
  input  logic                         ctrlWr,
  input  logic [7:0]                   ctrlIn,
  input  logic                         keyWr,
  input  logic [7:0]                   keyIn,
  input  logic [$clog2(MEM_BYTES)-1:0] rdAddr,
  output logic [7:0]                   rdData,
  output logic [$clog2(MEM_BYTES)-1:0] ptrOut,
  output logic [7:0]                   ctrlOut,
  output logic                         stall,
  output logic                         doneIrq
);
  dpStrobe_t stb;

  flash_prog_fsm #(.WRITE_CYCLES(WRITE_CYCLES)) u_fsm (
    .clk(clk), .rstN(rstN), .tblWr(tblWr), .ptrLoad(ptrLoad),
    .ctrlWr(ctrlWr), .ctrlIn(ctrlIn), .keyWr(keyWr), .keyIn(keyIn),
    .stb(stb), .ctrlReg(ctrlOut), .busy(stall), .doneIrq(doneIrq)
  );

  flash_prog_dp #(
    .MEM_BYTES(MEM_BYTES), .BLOCK_BYTES(BLOCK_BYTES), .ERASE_BYTES(ERASE_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ptrIn(ptrIn), .tblData(tblData),
    .rdAddr(rdAddr), .rdData(rdData), .ptrOut(ptrOut)
  );
endmodule

// File: rtl/flash_prog_chk.sv
module flash_prog_chk #(
  parameter int AW           = 11,
  parameter int WRITE_CYCLES = 40
) (
  input logic          clk,
  input logic          rstN,
  input logic          stall,
  input logic          doneIrq,
  input logic [7:0]    ctrlOut,
  input logic [AW-1:0] ptrOut
);
  logic [31:0] stallLen;
  always_ff @(posedge clk) begin
    if (!rstN) stallLen <= '0;
    else if (stall) stallLen <= stallLen + 1;
    else stallLen <= '0;
  end

  p_launch_bit_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stall) |-> ctrlOut[0]);
  p_stall_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall) |-> stallLen == 32'(WRITE_CYCLES));
  p_enable_needed_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stall) |-> ctrlOut[2]);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);
  p_done_end_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> (!stall && !ctrlOut[0] && $past(stall)));
  p_frozen_ptr_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stall && $past(stall)) |-> $stable(ptrOut));
endmodule

bind flash_prog_ctrl flash_prog_chk #(
  .AW($clog2(MEM_BYTES)), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .stall(stall), .doneIrq(doneIrq),
  .ctrlOut(ctrlOut), .ptrOut(ptrOut)
);

// File: tb/flash_prog_ctrl_test.sv
module flash_prog_ctrl_test;
  localparam int WC = 16;
  logic clk = 0, rstN = 0;
  logic ptrLoad = 0, tblWr = 0, ctrlWr = 0, keyWr = 0;
  logic [10:0] ptrIn = 0, rdAddr = 0;
  logic [7:0] tblData = 0, ctrlIn = 0, keyIn = 0;
  logic [7:0] rdData, ctrlOut;
  logic [10:0] ptrOut;
  logic stall, doneIrq;
  int errs = 0, checks = 0;

  always #2 clk = ~clk;

  flash_prog_ctrl #(.WRITE_CYCLES(WC)) uut (
    .clk(clk), .rstN(rstN), .ptrLoad(ptrLoad), .ptrIn(ptrIn), .tblWr(tblWr),
    .tblData(tblData), .ctrlWr(ctrlWr), .ctrlIn(ctrlIn), .keyWr(keyWr),
    .keyIn(keyIn), .rdAddr(rdAddr), .rdData(rdData), .ptrOut(ptrOut),
    .ctrlOut(ctrlOut), .stall(stall), .doneIrq(doneIrq)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37) ^ 8'hA5);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic memIs(string req, int a, logic [7:0] exp);
    rdAddr = 11'(a);
    #1;
    check(req, rdData, exp);
  endtask

  task automatic wrPtr(int p);
    ptrLoad = 1; ptrIn = 11'(p);
    @(negedge clk); ptrLoad = 0;
  endtask
  task automatic wrTbl(logic [7:0] d);
    tblWr = 1; tblData = d;
    @(negedge clk); tblWr = 0;
  endtask
  task automatic wrKey(logic [7:0] k);
    keyWr = 1; keyIn = k;
    @(negedge clk); keyWr = 0;
  endtask
  task automatic wrCtrl(logic [7:0] c);
    ctrlWr = 1; ctrlIn = c;
    @(negedge clk); ctrlWr = 0;
  endtask

  task automatic launch(logic [7:0] c, bit intrude);
    int n;
    wrKey(8'h55); wrKey(8'hAA); wrCtrl(c);
    check("R3 stall raised", stall, 1);
    check("R3 launch bit set", ctrlOut[0], 1);
    n = 0;
    if (intrude) begin
      ptrLoad = 1; ptrIn = 11'h123; tblWr = 1; tblData = 8'hEE;
      keyWr = 1; keyIn = 8'h55;
      @(negedge clk); ptrLoad = 0; tblWr = 0; keyWr = 0; n++;
      check("R11 pointer frozen", ptrOut, 11'h080);
    end
    while (stall && n < 1000) begin n++; @(negedge clk); end
    check("R3 stall length", n, WC);
    check("R10 done pulse", doneIrq, 1);
    check("R10 launch cleared", ctrlOut, {c[7:1], 1'b0} & 8'h16);
    @(negedge clk);
    check("R10 done one cycle", doneIrq, 0);
  endtask

  task automatic t_reset();
    check("R1 ptr", ptrOut, 0);
    check("R1 ctrl", ctrlOut, 0);
    check("R1 stall", stall, 0);
    check("R1 done", doneIrq, 0);
    memIs("R1 mem low", 0, 8'hFF);
    memIs("R1 mem high", 2047, 8'hFF);
  endtask

  task automatic t_fill();
    wrPtr(11'h080);
    for (int i = 0; i < 64; i++) wrTbl(pat(i));
    check("R2 ptr advanced", ptrOut, 11'h0C0);
    memIs("R2 array untouched", 11'h080, 8'hFF);
  endtask

  task automatic t_badKeys();
    wrPtr(11'h080);
    wrKey(8'h55); wrKey(8'h56); wrKey(8'hAA); wrCtrl(8'h05);
    check("R4 wrong key no stall", stall, 0);
    check("R4 wrong key launch bit", ctrlOut[0], 0);
    wrKey(8'hAA); wrKey(8'h55); wrCtrl(8'h05);
    check("R4 order no stall", stall, 0);
    wrKey(8'h55); wrKey(8'hAA); wrPtr(11'h080); wrCtrl(8'h05);
    check("R4 interrupted no stall", stall, 0);
    memIs("R4 array untouched", 11'h080, 8'hFF);
    wrKey(8'h55); wrKey(8'hAA); wrCtrl(8'h01);
    check("R5 no enable no stall", stall, 0);
    check("R5 launch bit", ctrlOut[0], 0);
  endtask

  task automatic t_block();
    wrPtr(11'h080);
    launch(8'h05, 1);
    check("R11 ptr after write", ptrOut, 11'h080);
    memIs("R6 first byte", 11'h080, pat(0));
    memIs("R6 mid byte", 11'h0A1, pat(33));
    memIs("R6 last byte", 11'h0BF, pat(63));
    memIs("R6 below block", 11'h07F, 8'hFF);
    memIs("R6 above block", 11'h0C0, 8'hFF);
  endtask

  task automatic t_persistAnd();
    wrPtr(11'h0C0);
    launch(8'h05, 0);
    memIs("R8 persisted byte0 (R11 buffer kept)", 11'h0C0, pat(0));
    memIs("R8 persisted byte63", 11'h0FF, pat(63));
    wrTbl(8'h0F);
    launch(8'h05, 0);
    memIs("R6 AND result", 11'h0C0, pat(0) & 8'h0F);
    memIs("R6 AND neighbour", 11'h0C1, pat(1));
  endtask

  task automatic t_word();
    wrPtr(11'h104);
    wrTbl(8'h11); wrTbl(8'h22);
    wrPtr(11'h105);
    launch(8'h07, 0);
    memIs("R7 pair low", 11'h104, 8'h11);
    memIs("R7 pair high", 11'h105, 8'h22);
    memIs("R7 after pair", 11'h106, 8'hFF);
    memIs("R7 before pair", 11'h103, 8'hFF);
  endtask

  task automatic t_erase();
    wrPtr(11'h400);
    launch(8'h05, 0);
    memIs("R9 region1 programmed", 11'h400, 8'h0F);
    wrPtr(11'h0C0);
    launch(8'h15, 0);
    memIs("R9 erased 080", 11'h080, 8'hFF);
    memIs("R9 erased 104", 11'h104, 8'hFF);
    memIs("R9 erased 3FF", 11'h3FF, 8'hFF);
    memIs("R9 other region kept", 11'h400, 8'h0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_badKeys();
    t_block();
    t_persistAnd();
    t_word();
    t_erase();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule